// File: doc/BRIEF.md
# Shift-Based Triplet Finder

This block finds straight-line track candidates across three detector planes. A track leaves one hit on each plane. The three coordinates form a triplet when the middle one is the mean of the outer two, that is `a + c = 2*b`. The block works in two phases for each event.

In the fill phase, hits from the two outer planes are written into two bit arrays, one bit per coordinate. The outer-C array is stored in mirrored order. Because of this, a single right shift of that array lines every candidate C partner up with its A coordinate. In the match phase, each middle-plane hit drives a logarithmic barrel shifter, which moves the mirrored array by an amount set by the hit's coordinate. One shared AND stage then compares the shifted array with the A array. Every surviving bit is a valid pair. A priority picker reports these pairs one per cycle as complete triplets. While more than one pair is still waiting, the block holds off further input. A clear input empties the arrays between events.

Top module: `tf_triplet_finder`

## Requirements
- R1: After reset, `trip_valid` is 0 and `hit_ready` is 1, and both hit arrays are empty, so a middle-plane query finds nothing.
- R2: Plane codes are 0 for outer plane A, 1 for the middle plane B and 2 for outer plane C. An accepted A or C hit at coordinate x records x for its plane. The record stays until `clear`, whatever later hits arrive.
- R3: A hit with plane code 3 is taken without effect: it records nothing and produces no output.
- R4: An accepted B hit at coordinate b reports exactly the stored pairs (a, c) with a + c = 2b and both coordinates in range 0..2^W-1. Each report carries a, b and c on `trip_a`, `trip_b` and `trip_c`.
- R5: The reports for one B hit come on consecutive cycles, in ascending order of a. The first report is valid in the second cycle after the B hit's accepting edge.
- R6: `hit_ready` is low whenever more than one report of the current B hit is still to be sent. A hit offered while `hit_ready` is low is not taken.
- R7: `clear` empties both arrays, discards unsent reports and forces `trip_valid` low on the next cycle. A hit offered in the same cycle as `clear` is dropped.
- R8: A B hit with no matching pair produces no report and leaves `hit_ready` high.
- R9: Writing the same outer-plane coordinate twice has the same effect as writing it once, so each valid pair is reported once.
- R10: Matches at the coordinate extremes are found: b = 0 pairs with a = c = 0, and b = 2^W-1 pairs with a = c = 2^W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Empties the arrays and pending reports before an event |
| hit_valid | input | 1 | A hit is offered this cycle |
| hit_plane | input | 2 | Plane code: 0 = A, 1 = B, 2 = C, 3 = none |
| hit_coord | input | W | Hit coordinate |
| hit_ready | output | 1 | Block accepts a hit this cycle |
| trip_valid | output | 1 | A triplet is reported |
| trip_a | output | W | Plane A coordinate of the triplet |
| trip_b | output | W | Plane B coordinate of the triplet |
| trip_c | output | W | Plane C coordinate of the triplet |

## Verification
The assertions take three things for granted: `hit_plane` and `hit_coord` are known whenever `hit_valid` is high, `clear` is a single known level in each cycle, and the source honours `hit_ready` before it counts a hit as delivered. The stimulus drives all inputs on the falling edge. Before it raises `hit_valid`, it waits for `hit_ready`, so a stalled B hit is never lost. The one exception is the clear-collision case, which offers a hit alongside `clear` on purpose and expects it to be dropped.

// File: rtl/tf_pkg.sv
package tf_pkg;

    localparam int TF_COORD_W = 5;

    typedef enum logic [1:0] {
        PL_A    = 2'd0,
        PL_B    = 2'd1,
        PL_C    = 2'd2,
        PL_NONE = 2'd3
    } plane_e;

    // Shift that aligns the mirrored C array, held in the upper half of a
    // double-width word, with the A array for a middle coordinate b.
    function automatic logic [TF_COORD_W:0] align_shift(input logic [TF_COORD_W-1:0] b);
        logic [TF_COORD_W:0] full;
        full = {(TF_COORD_W+1){1'b1}};
        return full - {b, 1'b0};
    endfunction

    // Partner coordinate on plane C for a given A coordinate and middle b.
    function automatic logic [TF_COORD_W-1:0] partner_c(input logic [TF_COORD_W-1:0] b,
                                                        input logic [TF_COORD_W-1:0] a);
        logic [TF_COORD_W:0] twice_b;
        logic [TF_COORD_W:0] diff;
        twice_b = {b, 1'b0};
        diff    = twice_b - {1'b0, a};
        return diff[TF_COORD_W-1:0];
    endfunction

endpackage

// File: rtl/tf_hit_array.sv
module tf_hit_array #(
    parameter int COORD_W  = 5,
    parameter bit MIRRORED = 1'b0,
    localparam int N = 1 << COORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wipe,
    input  logic               set_en,
    input  logic [COORD_W-1:0] set_coord,
    output logic [N-1:0]       bits
);
    logic [COORD_W-1:0] slot;

    generate
        if (MIRRORED) begin : g_mirror
            assign slot = ~set_coord;   // N-1-x
        end else begin : g_direct
            assign slot = set_coord;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            bits <= '0;
        end else if (set_en) begin
            bits[slot] <= 1'b1;
        end
    end
endmodule

// File: rtl/tf_log_shr.sv
module tf_log_shr #(
    parameter int DATA_W  = 64,
    parameter int SHIFT_W = 6
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHIFT_W-1:0] amount,
    output logic [DATA_W-1:0]  dout
);
    logic [DATA_W-1:0] stage [SHIFT_W+1];

    assign stage[0] = din;

    generate
        for (genvar s = 0; s < SHIFT_W; s++) begin : g_stage
            assign stage[s+1] = amount[s] ? (stage[s] >> (1 << s)) : stage[s];
        end
    endgenerate

    assign dout = stage[SHIFT_W];
endmodule

// File: rtl/tf_low_pick.sv
module tf_low_pick #(
    parameter int COORD_W = 5,
    localparam int N = 1 << COORD_W
) (
    input  logic [N-1:0]       vec,
    output logic               any,
    output logic [COORD_W-1:0] idx,
    output logic [N-1:0]       rest
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = COORD_W'(i);
        end
    end

    assign any  = |vec;
    assign rest = vec & (vec - N'(1));
endmodule

// File: rtl/tf_triplet_finder.sv
module tf_triplet_finder
    import tf_pkg::*;
#(
    parameter int COORD_W = TF_COORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               hit_valid,
    input  logic [1:0]         hit_plane,
    input  logic [COORD_W-1:0] hit_coord,
    output logic               hit_ready,
    output logic               trip_valid,
    output logic [COORD_W-1:0] trip_a,
    output logic [COORD_W-1:0] trip_b,
    output logic [COORD_W-1:0] trip_c
);
    localparam int N       = 1 << COORD_W;
    localparam int EXT_W   = 2 * N;
    localparam int SHIFT_W = COORD_W + 1;

    plane_e             plane;
    logic               accept;
    logic               set_a;
    logic               set_c;
    logic               take_b;
    logic [N-1:0]       arr_a;
    logic [N-1:0]       arr_c;
    logic [EXT_W-1:0]   ext_c;
    logic [EXT_W-1:0]   shifted_c;
    logic [SHIFT_W-1:0] shift_amt;
    logic [N-1:0]       match;
    logic [N-1:0]       pend;
    logic [COORD_W-1:0] pend_b;
    logic               pend_any;
    logic [COORD_W-1:0] pick;
    logic [N-1:0]       pend_rest;

    assign plane  = plane_e'(hit_plane);
    assign accept = hit_valid && hit_ready && !clear;
    assign set_a  = accept && (plane == PL_A);
    assign set_c  = accept && (plane == PL_C);
    assign take_b = accept && (plane == PL_B);

    // Ready while at most one pair of the previous middle hit remains.
    assign hit_ready = (pend_rest == '0);

    tf_hit_array #(.COORD_W(COORD_W), .MIRRORED(1'b0)) u_arr_a (
        .clk(clk), .rst(rst), .wipe(clear),
        .set_en(set_a), .set_coord(hit_coord), .bits(arr_a)
    );

    tf_hit_array #(.COORD_W(COORD_W), .MIRRORED(1'b1)) u_arr_c (
        .clk(clk), .rst(rst), .wipe(clear),
        .set_en(set_c), .set_coord(hit_coord), .bits(arr_c)
    );

    assign ext_c     = {arr_c, {N{1'b0}}};
    assign shift_amt = SHIFT_W'(align_shift(TF_COORD_W'(hit_coord)));

    tf_log_shr #(.DATA_W(EXT_W), .SHIFT_W(SHIFT_W)) u_shift (
        .din(ext_c), .amount(shift_amt), .dout(shifted_c)
    );

    assign match = arr_a & shifted_c[N-1:0];

    tf_low_pick #(.COORD_W(COORD_W)) u_pick (
        .vec(pend), .any(pend_any), .idx(pick), .rest(pend_rest)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend   <= '0;
            pend_b <= '0;
        end else if (take_b) begin
            pend   <= match;
            pend_b <= hit_coord;
        end else begin
            pend   <= pend_rest;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            trip_valid <= 1'b0;
            trip_a     <= '0;
            trip_b     <= '0;
            trip_c     <= '0;
        end else begin
            trip_valid <= pend_any;
            if (pend_any) begin
                trip_a <= pick;
                trip_b <= pend_b;
                trip_c <= COORD_W'(partner_c(TF_COORD_W'(pend_b), TF_COORD_W'(pick)));
            end
        end
    end
endmodule

// File: rtl/tf_triplet_finder_chk.sv
module tf_triplet_finder_chk #(
    parameter int COORD_W = 5,
    localparam int N = 1 << COORD_W
) (
    input logic               clk,
    input logic               rst,
    input logic               clear,
    input logic               hit_ready,
    input logic               trip_valid,
    input logic [COORD_W-1:0] trip_a,
    input logic [COORD_W-1:0] trip_b,
    input logic [COORD_W-1:0] trip_c,
    input logic [N-1:0]       arr_a,
    input logic [N-1:0]       arr_c
);
    AST_FILL_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (((arr_a & $past(arr_a)) == $past(arr_a)) && ((arr_c & $past(arr_c)) == $past(arr_c)))); // R2

    AST_TRIP_STORED: assert property (@(posedge clk) disable iff (rst)
        trip_valid |-> (arr_a[trip_a] && arr_c[~trip_c])); // R4

    AST_TRIP_SUM: assert property (@(posedge clk) disable iff (rst)
        trip_valid |-> (({1'b0, trip_a} + {1'b0, trip_c}) == {trip_b, 1'b0})); // R4

    AST_STALL_EMITS: assert property (@(posedge clk) disable iff (rst)
        (!hit_ready && !clear) |=> trip_valid); // R6

    AST_CLEAR_FLUSH: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!trip_valid && (arr_a == '0) && (arr_c == '0))); // R7
endmodule

bind tf_triplet_finder tf_triplet_finder_chk #(.COORD_W(COORD_W)) u_chk (
    .clk(clk), .rst(rst), .clear(clear), .hit_ready(hit_ready),
    .trip_valid(trip_valid), .trip_a(trip_a), .trip_b(trip_b), .trip_c(trip_c),
    .arr_a(arr_a), .arr_c(arr_c)
);

// File: tb/tf_triplet_finder_tb.sv
module tf_triplet_finder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clear = 1'b0;
    logic       hit_valid = 1'b0;
    logic [1:0] hit_plane = 2'd0;
    logic [4:0] hit_coord = 5'd0;
    logic       hit_ready;
    logic       trip_valid;
    logic [4:0] trip_a, trip_b, trip_c;

    int total = 0;
    int fails = 0;
    bit [31:0] ma = '0;
    bit [31:0] mc = '0;

    // {plane[1:0], coord[4:0]}; plane 1 entries are queries
    localparam logic [6:0] VECS [0:13] = '{
        {2'd0, 5'd3},  {2'd0, 5'd7},  {2'd0, 5'd10}, {2'd0, 5'd20},
        {2'd2, 5'd7},  {2'd2, 5'd0},  {2'd2, 5'd20}, {2'd2, 5'd13},
        {2'd1, 5'd10}, {2'd1, 5'd5},  {2'd1, 5'd20}, {2'd1, 5'd1},
        {2'd1, 5'd0},  {2'd1, 5'd31}
    };

    always #4 clk = ~clk;

    tf_triplet_finder u_dut (
        .clk(clk), .rst(rst), .clear(clear),
        .hit_valid(hit_valid), .hit_plane(hit_plane), .hit_coord(hit_coord),
        .hit_ready(hit_ready), .trip_valid(trip_valid),
        .trip_a(trip_a), .trip_b(trip_b), .trip_c(trip_c)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic drive_hit(input logic [1:0] pl, input logic [4:0] x);
        while (!hit_ready) @(negedge clk);
        hit_valid = 1'b1; hit_plane = pl; hit_coord = x;
        @(negedge clk);
        hit_valid = 1'b0;
        if (pl == 2'd0) ma[x] = 1'b1;
        else if (pl == 2'd2) mc[x] = 1'b1;
    endtask

    task automatic query(input logic [4:0] xb);
        int ea [32];
        int n = 0;
        for (int a = 0; a < 32; a++) begin
            int c = 2 * int'(xb) - a;
            if (ma[a] && c >= 0 && c < 32 && mc[c]) begin
                ea[n] = a;
                n++;
            end
        end
        drive_hit(2'd1, xb);
        chk(hit_ready == (n <= 1), "R6 ready after query", int'(hit_ready), int'(n <= 1));
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(trip_valid == 1'b1, "R5 report valid", int'(trip_valid), 1);
            chk(int'(trip_a) == ea[k], "R4 trip_a", int'(trip_a), ea[k]);
            chk(trip_b == xb, "R4 trip_b", int'(trip_b), int'(xb));
            chk(int'(trip_c) == 2 * int'(xb) - ea[k], "R4 trip_c", int'(trip_c), 2 * int'(xb) - ea[k]);
            chk(hit_ready == (n - k - 1 <= 1), "R6 ready during drain", int'(hit_ready), int'(n - k - 1 <= 1));
        end
        @(negedge clk);
        chk(trip_valid == 1'b0, "R5 R8 no extra report", int'(trip_valid), 0);
        chk(hit_ready == 1'b1, "R8 ready after drain", int'(hit_ready), 1);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        ma = '0; mc = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(trip_valid == 1'b0, "R1 trip_valid", int'(trip_valid), 0);
        chk(hit_ready == 1'b1, "R1 hit_ready", int'(hit_ready), 1);
        query(5'd0);   // R1 empty arrays

        // table-driven fill and queries (R2 R4 R5 R6 R8)
        foreach (VECS[i]) begin
            if (VECS[i][6:5] == 2'd1) query(VECS[i][4:0]);
            else drive_hit(VECS[i][6:5], VECS[i][4:0]);
        end

        // R3 plane code 3 ignored
        do_clear();
        drive_hit(2'd3, 5'd6);
        drive_hit(2'd2, 5'd6);
        query(5'd6);   // plane-3 hit would pair A6 with C6
        drive_hit(2'd0, 5'd6);
        query(5'd6);   // now one report

        // R9 duplicate writes
        do_clear();
        drive_hit(2'd0, 5'd4); drive_hit(2'd0, 5'd4);
        drive_hit(2'd2, 5'd8); drive_hit(2'd2, 5'd8);
        query(5'd6);

        // R10 extremes
        do_clear();
        drive_hit(2'd0, 5'd0);  drive_hit(2'd2, 5'd0);
        drive_hit(2'd0, 5'd31); drive_hit(2'd2, 5'd31);
        query(5'd0);
        query(5'd31);

        // R7 hit together with clear is dropped
        clear = 1'b1; hit_valid = 1'b1; hit_plane = 2'd0; hit_coord = 5'd9;
        @(negedge clk);
        clear = 1'b0; hit_valid = 1'b0;
        ma = '0; mc = '0;
        drive_hit(2'd2, 5'd9);
        query(5'd9);   // R7 expects nothing

        // R6 long stall: full arrays
        do_clear();
        for (int x = 0; x < 32; x++) begin
            drive_hit(2'd0, 5'(x));
            drive_hit(2'd2, 5'(x));
        end
        query(5'd15);

        // R7 clear discards pending reports
        drive_hit(2'd1, 5'd16);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        ma = '0; mc = '0;
        chk(trip_valid == 1'b0, "R7 flush after clear", int'(trip_valid), 0);
        @(negedge clk);
        chk(trip_valid == 1'b0, "R7 stays flushed", int'(trip_valid), 0);
        chk(hit_ready == 1'b1, "R7 ready after clear", int'(hit_ready), 1);
        query(5'd16);  // R7 arrays empty

        summary();
    end
endmodule